// File: doc/BRIEF.md
# Strobe-Handshake Read Servant

This block sits on the servant side of a simple read bus. A master asks for a word by raising `req`. The servant then starts a fetch from an internal source whose latency varies. It answers on a data bus with a valid flag, plus a `waitLine` that warns the master when the answer will be late.

The protocol switches between two modes on each transfer. If the source returns within a fixed access window, the word goes straight onto the bus and `waitLine` never moves, so the master can treat the exchange as a plain strobe. If the window runs out first, the servant raises `waitLine` and keeps it high until the word arrives. The word is then driven and `waitLine` falls in the same cycle, and the exchange becomes a handshake.

In both modes the word stays on the bus until the master drops `req`. After that the servant is idle again and waits for a fresh request.

Top module: `hsServant`

## Requirements
- R1: While `rstN` is low and just after it is released, `waitLine` and `busValid` are 0 and `busData` is 0.
- R2: `srcStart` is high for exactly one cycle, the cycle in which `req` is high while the servant is idle. The edge that ends that cycle is the acceptance edge.
- R3: If `srcValid` is sampled high at any of the first `ACCESS` rising edges after the acceptance edge, `busValid` goes high after that edge. `busData` then equals the `srcData` sampled at that edge, and `waitLine` stays 0 for the whole transfer.
- R4: If `srcValid` is low at all of the first `ACCESS` edges after acceptance, `waitLine` is 1 after edge number `ACCESS`. It stays 0 before that edge.
- R5: `waitLine` stays high until an edge samples `srcValid` high. After that edge `waitLine` is 0, `busValid` is 1 and `busData` holds the sampled `srcData`.
- R6: While `busValid` is high and `req` stays high, `busValid` and `busData` do not change.
- R7: When `req` is low at an edge while `busValid` is high, `busValid` and `busData` both go to 0 after that edge.
- R8: A `req` that stays high after its data has been delivered starts no new transfer: `srcStart` stays 0 until `req` has been low at an edge.
- R9: `srcValid` has no effect when no fetch is pending, either while idle or while data is held. In those states `busData` and `busValid` do not change.
- R10: `waitLine` and `busValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request from the master |
| srcValid | input | 1 | Internal source reports its word is ready |
| srcData | input | DATA_W | Word from the internal source |
| srcStart | output | 1 | One-cycle fetch start to the internal source |
| waitLine | output | 1 | Late-response flag to the master |
| busValid | output | 1 | Data on `busData` is valid |
| busData | output | DATA_W | Read data bus toward the master |

## Verification
The checker watches several rules on every cycle. It confirms that `waitLine` and `busValid` are never high together. It confirms that no pending fetch gets past `ACCESS` edges without one of the two showing. It also confirms that held data stays stable while `req` is high, that release follows a low `req` at once, and that a falling `waitLine` always comes with valid data. The bench sweeps the source latency from inside the window to well past it. Only those scenarios can show that the exact word sampled is the one driven, that the switch between fast and slow modes happens at the right edge, and that stray `srcValid` pulses and a lingering `req` are ignored.

// File: rtl/hsServantPkg.sv
package hsServantPkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_LATE   = 2'd2,
    ST_HOLD   = 2'd3
  } servState_t;

  typedef struct packed {
    logic loadWord;
    logic clearWord;
  } dpStrobe_t;
endpackage

// File: rtl/hsServantCtrl.sv
module hsServantCtrl
  import hsServantPkg::*;
#(
  parameter int ACCESS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      req,
  input  logic      srcValid,
  output logic      srcStart,
  output logic      waitLine,
  output logic      busValid,
  output dpStrobe_t strobe
);
  localparam int CNT_W = (ACCESS > 1) ? $clog2(ACCESS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS - 1);

  servState_t state, stateNext;
  logic [CNT_W-1:0] winCnt, winCntNext;

  always_comb begin
    stateNext  = state;
    winCntNext = winCnt;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          stateNext  = ST_WINDOW;
          winCntNext = '0;
        end
      end
      ST_WINDOW: begin
        if (srcValid) begin
          stateNext = ST_HOLD;
        end else if (winCnt == LAST) begin
          stateNext = ST_LATE;
        end else begin
          winCntNext = winCnt + 1'b1;
        end
      end
      ST_LATE: begin
        if (srcValid) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (!req) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else begin
      state  <= stateNext;
      winCnt <= winCntNext;
    end
  end

  assign srcStart        = (state == ST_IDLE) && req;
  assign waitLine        = (state == ST_LATE);
  assign busValid        = (state == ST_HOLD);
  assign strobe.loadWord  = ((state == ST_WINDOW) || (state == ST_LATE)) && srcValid;
  assign strobe.clearWord = (state == ST_HOLD) && !req;
endmodule

// File: rtl/hsServantData.sv
module hsServantData
  import hsServantPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] busData
);
  logic [DATA_W-1:0] wordReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strobe.clearWord) begin
      wordReg <= '0;
    end else if (strobe.loadWord) begin
      wordReg <= srcData;
    end
  end

  assign busData = wordReg;
endmodule

// File: rtl/hsServant.sv
module hsServant
  import hsServantPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACCESS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcStart,
  output logic              waitLine,
  output logic              busValid,
  output logic [DATA_W-1:0] busData
);
  dpStrobe_t strobe;

  hsServantCtrl #(.ACCESS(ACCESS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .srcValid (srcValid),
    .srcStart (srcStart),
    .waitLine (waitLine),
    .busValid (busValid),
    .strobe   (strobe)
  );

  hsServantData #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcData (srcData),
    .busData (busData)
  );
endmodule

// File: rtl/hsServantChecker.sv
module hsServantChecker #(
  parameter int DATA_W = 8,
  parameter int ACCESS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              srcStart,
  input logic              waitLine,
  input logic              busValid,
  input logic [DATA_W-1:0] busData
);
  localparam int PC_W = $clog2(ACCESS + 2);

  logic            pending;
  logic [PC_W-1:0] pendCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendCnt <= '0;
    end else if (srcStart) begin
      pending <= 1'b1;
      pendCnt <= '0;
    end else if (busValid || waitLine) begin
      pending <= 1'b0;
    end else if (pending && (pendCnt < PC_W'(ACCESS))) begin
      pendCnt <= pendCnt + 1'b1;
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(waitLine && busValid));

  assert_window_met_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pending && (pendCnt >= PC_W'(ACCESS))) |-> (waitLine || busValid));

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    srcStart |=> !srcStart);

  assert_wait_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(waitLine) |-> busValid);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && req) |=> (busValid && $stable(busData)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !req) |=> (!busValid && (busData == '0)));
endmodule

bind hsServant hsServantChecker #(.DATA_W(DATA_W), .ACCESS(ACCESS)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .req      (req),
  .srcStart (srcStart),
  .waitLine (waitLine),
  .busValid (busValid),
  .busData  (busData)
);

// File: tb/hsServant_tb.sv
module hsServant_tb;
  localparam int DATA_W = 8;
  localparam int ACCESS = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              req;
  logic              srcValid;
  logic [DATA_W-1:0] srcData;
  logic              srcStart;
  logic              waitLine;
  logic              busValid;
  logic [DATA_W-1:0] busData;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hsServant #(.DATA_W(DATA_W), .ACCESS(ACCESS)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .srcValid (srcValid),
    .srcData  (srcData),
    .srcStart (srcStart),
    .waitLine (waitLine),
    .busValid (busValid),
    .busData  (busData)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; req = 1'b0; srcValid = 1'b0; srcData = '0;
    @(negedge clk);
    tick();
    check("R1 wait in reset", waitLine, 0);
    check("R1 valid in reset", busValid, 0);
    check("R1 data in reset", busData, 0);
    rstN = 1'b1;
    tick();
    check("R1 wait after reset", waitLine, 0);
    check("R1 valid after reset", busValid, 0);

    // R9: a stray ready while idle must not load the bus
    srcValid = 1'b1; srcData = 8'h55;
    tick();
    srcValid = 1'b0;
    check("R9 idle valid", busValid, 0);
    check("R9 idle data", busData, 0);

    for (int lat = 1; lat <= ACCESS + 3; lat++) begin
      logic [DATA_W-1:0] pat;
      pat = DATA_W'(8'hA0 + lat * 7);
      req = 1'b1;
      #1;
      check("R2 start on accept", srcStart, 1);
      tick();
      check("R2 start single", srcStart, 0);
      check("R4 no wait at accept", waitLine, 0);
      for (int j = 1; j <= lat; j++) begin
        srcValid = (j == lat);
        srcData  = (j == lat) ? pat : 8'h00;
        tick();
        srcValid = 1'b0;
        if (j < lat) begin
          check("R4 wait timing", waitLine, (j >= ACCESS) ? 1 : 0);
          check("R4 no data yet", busValid, 0);
        end else if (lat <= ACCESS) begin
          check("R3 fast valid", busValid, 1);
          check("R3 fast data", busData, pat);
          check("R3 fast no wait", waitLine, 0);
        end else begin
          check("R5 slow valid", busValid, 1);
          check("R5 slow data", busData, pat);
          check("R5 wait dropped", waitLine, 0);
        end
      end
      // R9 and R8: stray ready while holding, with req still high
      srcValid = 1'b1; srcData = ~pat;
      tick();
      srcValid = 1'b0;
      check("R6 held valid", busValid, 1);
      check("R9 held data", busData, pat);
      check("R8 no restart", srcStart, 0);
      tick();
      check("R6 held data", busData, pat);
      check("R8 no restart late", srcStart, 0);
      req = 1'b0;
      tick();
      check("R7 valid cleared", busValid, 0);
      check("R7 data cleared", busData, 0);
      check("R10 wait low idle", waitLine, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule